// File: doc/BRIEF.md
# DMA Watchpoint Debug Halt Unit

This unit sits beside a transfer engine and watches every main-memory address that the engine issues. Each transfer carries a small tag naming the channel packet that produced it. When a valid transfer's address matches a programmed watch address, and its tag equals a programmed packet number, the unit latches a sticky hit flag. If halting is enabled, it raises a halt request to the processor. Address bits that are set in a mask register are ignored in the compare, so one watchpoint can cover an aligned range.

Software reaches three 32-bit registers over a simple register bus: control/status, watch address and watch mask. The halt enable bit, the hit flag clear and both watch registers can be changed only while the debug-mode input is high. A debug tool therefore decides when halting is armed. Writing 1 to the hit flag clears it, and that releases the processor. All three registers respond only to the test reset. The functional reset flushes the compare pipeline and nothing else, so a watchpoint survives a system reset.

Top module: `dma_watch_halt`

## Requirements
- R1: A transfer with `xfer_valid` high hits when `((xfer_addr ^ watch_addr) & ~watch_mask) == 0` and its tag matches. The hit flag (control bit 16) reads 1 after the second rising clock edge following the transfer.
- R2: The tag must equal the packet-number field, control bits 27:24. Code = 2 × descriptor index (0..7) + half (0 = A, 1 = B). A transfer whose tag differs never sets the hit flag.
- R3: While `xfer_valid` is low, no address or tag value sets the hit flag.
- R4: The hit flag is sticky. A control write with bit 16 = 1 while `dbg_mode` is high clears it. Writing 0 to bit 16, or any write while `dbg_mode` is low, leaves it unchanged.
- R5: If a hit and a clear take effect on the same clock edge, the hit flag ends up set.
- R6: The halt enable (control bit 0) takes the written value only on control writes made while `dbg_mode` is high. At other times it holds.
- R7: `halt_req` is high exactly when the hit flag and the halt enable are both 1. Clearing the flag drops `halt_req`.
- R8: The watch address (offset 0x58) and the watch mask (offset 0x5C) read back what was written while `dbg_mode` was high. Writes made while `dbg_mode` is low are ignored. The control register is at offset 0x54.
- R9: A synchronous `trst` sets all three registers to 0. A synchronous `rst` leaves all register contents unchanged.
- R10: Control bits 31:28, 23:17 and 15:1 read as 0 whatever was written. A read at any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Functional reset, synchronous, active high; flushes the compare pipeline |
| trst | input | 1 | Test reset, synchronous, active high; clears all registers |
| dbg_mode | input | 1 | High while the processor is in suspend/debug mode |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| xfer_valid | input | 1 | Transfer strobe |
| xfer_addr | input | 32 | Main-memory address of the transfer |
| xfer_tag | input | 4 | Packet number of the transfer |
| halt_req | output | 1 | Halt request to the processor |

## Verification
The bench uses the default parameters: 32-bit addresses, a 4-bit tag and the 0x54/0x58/0x5C offsets. At these values the full tag space (codes 0 and F) and masks of all-zero, low-nibble, low-byte and all-ones are reachable, and so are wrap cases at the top of the address space. The 8-bit register offset also lets the bench probe an unmapped location. With the two-stage latency fixed, a hit and a clear can be aligned on one edge, so the set-wins rule is observable at the ports.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int unsigned REG_W = 32;

    // control register field positions
    localparam int unsigned CTL_EN_BIT   = 0;
    localparam int unsigned CTL_HIT_BIT  = 16;
    localparam int unsigned CTL_TAG_LSB  = 24;

    typedef struct packed {
        logic [3:0] pkt;
        logic       hit;
        logic       en;
    } ctl_view_t;

    function automatic logic [REG_W-1:0] pack_ctl(input ctl_view_t v);
        logic [REG_W-1:0] r;
        r = '0;
        r[CTL_TAG_LSB +: 4] = v.pkt;
        r[CTL_HIT_BIT]      = v.hit;
        r[CTL_EN_BIT]       = v.en;
        return r;
    endfunction

endpackage

// File: rtl/wp_regs.sv
module wp_regs
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned TAG_W   = 4,
    parameter int unsigned RAW     = 8,
    parameter logic [RAW-1:0] OFS_CTL  = 8'h54,
    parameter logic [RAW-1:0] OFS_WADR = 8'h58,
    parameter logic [RAW-1:0] OFS_WMSK = 8'h5C
) (
    input  logic              clk,
    input  logic              trst,
    input  logic              dbg_mode,
    input  logic              bus_wr,
    input  logic [RAW-1:0]    bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              hit_flag,
    input  logic              en_flag,
    output logic [ADDR_W-1:0] watch_addr,
    output logic [ADDR_W-1:0] watch_mask,
    output logic [TAG_W-1:0]  pkt_sel,
    output logic              ctl_wr,
    output logic [REG_W-1:0]  bus_rdata
);
    logic sel_ctl, sel_wadr, sel_wmsk;

    always_comb begin
        sel_ctl  = (bus_addr == OFS_CTL);
        sel_wadr = (bus_addr == OFS_WADR);
        sel_wmsk = (bus_addr == OFS_WMSK);
        ctl_wr   = bus_wr && sel_ctl;
    end

    always_ff @(posedge clk) begin
        if (trst) begin
            watch_addr <= '0;
            watch_mask <= '0;
            pkt_sel    <= '0;
        end else begin
            if (ctl_wr)
                pkt_sel <= bus_wdata[CTL_TAG_LSB +: TAG_W];
            if (bus_wr && sel_wadr && dbg_mode)
                watch_addr <= bus_wdata[ADDR_W-1:0];
            if (bus_wr && sel_wmsk && dbg_mode)
                watch_mask <= bus_wdata[ADDR_W-1:0];
        end
    end

    ctl_view_t cv;
    always_comb begin
        cv.pkt = 4'(pkt_sel);
        cv.hit = hit_flag;
        cv.en  = en_flag;
        bus_rdata = '0;
        if (sel_ctl)
            bus_rdata = pack_ctl(cv);
        else if (sel_wadr)
            bus_rdata[ADDR_W-1:0] = watch_addr;
        else if (sel_wmsk)
            bus_rdata[ADDR_W-1:0] = watch_mask;
    end

    // R8: watch registers are frozen outside debug mode
    a_r8_watch_locked: assert property (@(posedge clk) disable iff (trst)
        (!dbg_mode) |=> ($stable(watch_addr) && $stable(watch_mask)));

endmodule

// File: rtl/wp_match.sv
module wp_match #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_valid,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [TAG_W-1:0]  xfer_tag,
    input  logic [ADDR_W-1:0] watch_addr,
    input  logic [ADDR_W-1:0] watch_mask,
    input  logic [TAG_W-1:0]  pkt_sel,
    output logic              hit_q
);
    logic addr_ok, tag_ok;

    always_comb begin
        addr_ok = (((xfer_addr ^ watch_addr) & ~watch_mask) == '0);
        tag_ok  = (xfer_tag == pkt_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= xfer_valid && addr_ok && tag_ok;
    end

    // R3: an idle strobe never produces a hit pulse
    a_r3_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        (!xfer_valid) |=> !hit_q);

endmodule

// File: rtl/wp_status.sv
module wp_status
    import wp_pkg::*;
(
    input  logic             clk,
    input  logic             trst,
    input  logic             dbg_mode,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             hit_q,
    output logic             hit_flag,
    output logic             en_flag,
    output logic             halt_req
);
    logic clr_req, en_load;

    always_comb begin
        clr_req = ctl_wr && dbg_mode && bus_wdata[CTL_HIT_BIT];
        en_load = ctl_wr && dbg_mode;
    end

    always_ff @(posedge clk) begin
        if (trst) begin
            hit_flag <= 1'b0;
            en_flag  <= 1'b0;
        end else begin
            if (hit_q)        hit_flag <= 1'b1;
            else if (clr_req) hit_flag <= 1'b0;
            if (en_load)      en_flag  <= bus_wdata[CTL_EN_BIT];
        end
    end

    assign halt_req = hit_flag && en_flag;

    // R4: flag cannot drop outside debug mode
    a_r4_sticky: assert property (@(posedge clk) disable iff (trst)
        (hit_flag && !dbg_mode) |=> hit_flag);
    // R5: a hit always lands, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (trst)
        hit_q |=> hit_flag);
    // R6: enable frozen outside debug mode
    a_r6_en_locked: assert property (@(posedge clk) disable iff (trst)
        (!dbg_mode) |=> $stable(en_flag));

endmodule

// File: rtl/dma_watch_halt.sv
module dma_watch_halt
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned RAW    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trst,
    input  logic              dbg_mode,
    input  logic              bus_wr,
    input  logic [RAW-1:0]    bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              xfer_valid,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [TAG_W-1:0]  xfer_tag,
    output logic              halt_req
);
    logic [ADDR_W-1:0] watch_addr, watch_mask;
    logic [TAG_W-1:0]  pkt_sel;
    logic ctl_wr, hit_q, hit_flag, en_flag;

    wp_regs #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .RAW(RAW)) u_regs (
        .clk(clk), .trst(trst), .dbg_mode(dbg_mode),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .hit_flag(hit_flag), .en_flag(en_flag),
        .watch_addr(watch_addr), .watch_mask(watch_mask),
        .pkt_sel(pkt_sel), .ctl_wr(ctl_wr), .bus_rdata(bus_rdata)
    );

    wp_match #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_match (
        .clk(clk), .rst(rst), .xfer_valid(xfer_valid),
        .xfer_addr(xfer_addr), .xfer_tag(xfer_tag),
        .watch_addr(watch_addr), .watch_mask(watch_mask),
        .pkt_sel(pkt_sel), .hit_q(hit_q)
    );

    wp_status u_status (
        .clk(clk), .trst(trst), .dbg_mode(dbg_mode),
        .ctl_wr(ctl_wr), .bus_wdata(bus_wdata), .hit_q(hit_q),
        .hit_flag(hit_flag), .en_flag(en_flag), .halt_req(halt_req)
    );

    // R7: halt only while a hit is latched
    a_r7_halt_needs_hit: assert property (@(posedge clk) disable iff (trst)
        halt_req |-> bus_rdata[CTL_HIT_BIT] || (bus_addr != 8'h54));

endmodule

// File: tb/dma_watch_halt_bench.sv
module dma_watch_halt_bench;
    logic clk = 1'b0;
    logic rst = 1'b0, trst = 1'b1, dbg_mode = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        xfer_valid = 1'b0;
    logic [31:0] xfer_addr = '0;
    logic [3:0]  xfer_tag = '0;
    logic        halt_req;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    dma_watch_halt u_dma_watch_halt (
        .clk(clk), .rst(rst), .trst(trst), .dbg_mode(dbg_mode),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .xfer_valid(xfer_valid),
        .xfer_addr(xfer_addr), .xfer_tag(xfer_tag), .halt_req(halt_req)
    );

    localparam logic [7:0] A_CTL = 8'h54, A_WA = 8'h58, A_WM = 8'h5C;

    typedef struct packed {
        logic [31:0] wa;
        logic [31:0] wm;
        logic [31:0] xa;
        logic [3:0]  cp;
        logic [3:0]  tg;
        logic        exp_hit;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0000_1000, 32'h0000_0000, 32'h0000_1000, 4'h3, 4'h3, 1'b1},
        '{32'h0000_1000, 32'h0000_0000, 32'h0000_1004, 4'h3, 4'h3, 1'b0},
        '{32'h0000_1000, 32'h0000_00FF, 32'h0000_10AB, 4'h3, 4'h3, 1'b1},
        '{32'h0000_1000, 32'h0000_00FF, 32'h0000_11AB, 4'h3, 4'h3, 1'b0},
        '{32'h0000_1000, 32'h0000_0000, 32'h0000_1000, 4'h3, 4'h2, 1'b0},
        '{32'hFFFF_FFF0, 32'h0000_000F, 32'hFFFF_FFFF, 4'hF, 4'hF, 1'b1},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 4'h0, 4'h0, 1'b1},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 4'hA, 4'hB, 1'b0}
    };

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    // drive one transfer, then wait until the flag is visible
    task automatic xfer(input logic v, input logic [31:0] a, input logic [3:0] t);
        xfer_valid = v; xfer_addr = a; xfer_tag = t;
        tick();
        xfer_valid = 1'b0;
        tick();
    endtask

    function automatic logic [31:0] ctl(input logic [3:0] cp, input logic clr, input logic en);
        return {4'h0, cp, 7'h0, clr, 15'h0, en};
    endfunction

    initial begin
        #1_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        @(negedge clk); tick(); trst = 1'b0; tick();

        // R9: test reset state
        rd(A_CTL, d); check("R9 ctl after trst", d, 32'h0);
        rd(A_WA, d);  check("R9 waddr after trst", d, 32'h0);
        rd(A_WM, d);  check("R9 wmask after trst", d, 32'h0);
        check("R7 halt after trst", {31'h0, halt_req}, 32'h0);

        // R1/R2/R8: vector table
        dbg_mode = 1'b1;
        foreach (VECS[i]) begin
            wr(A_WA, VECS[i].wa);
            wr(A_WM, VECS[i].wm);
            wr(A_CTL, ctl(VECS[i].cp, 1'b1, 1'b0));
            rd(A_WM, d); check("R8 mask readback", d, VECS[i].wm);
            xfer(1'b1, VECS[i].xa, VECS[i].tg);
            rd(A_CTL, d);
            check("R1 R2 hit flag", {31'h0, d[16]}, {31'h0, VECS[i].exp_hit});
        end

        // R7: enable plus hit raises halt
        wr(A_WA, 32'h0000_2000); wr(A_WM, 32'h0);
        wr(A_CTL, ctl(4'h5, 1'b1, 1'b1));
        xfer(1'b1, 32'h0000_2000, 4'h5);
        check("R7 halt on hit", {31'h0, halt_req}, 32'h1);

        // R4/R6: writes outside debug mode
        dbg_mode = 1'b0;
        wr(A_CTL, ctl(4'h5, 1'b1, 1'b0));
        rd(A_CTL, d); check("R4 R6 no change outside debug", d, ctl(4'h5, 1'b1, 1'b1));
        wr(A_WA, 32'hDEAD_BEEF);
        rd(A_WA, d); check("R8 waddr locked", d, 32'h0000_2000);

        // R4: writing 0 to flag has no effect
        dbg_mode = 1'b1;
        wr(A_CTL, ctl(4'h5, 1'b0, 1'b1));
        rd(A_CTL, d); check("R4 write0 keeps flag", d, ctl(4'h5, 1'b1, 1'b1));

        // R9: functional reset keeps registers
        rst = 1'b1; tick(); rst = 1'b0; tick();
        rd(A_CTL, d); check("R9 rst keeps ctl", d, ctl(4'h5, 1'b1, 1'b1));
        rd(A_WA, d);  check("R9 rst keeps waddr", d, 32'h0000_2000);

        // R10/R4/R7: all-ones write clears flag, reserved bits zero
        wr(A_CTL, 32'hFFFF_FFFF);
        rd(A_CTL, d); check("R10 reserved zero", d, 32'h0F00_0001);
        check("R7 halt released", {31'h0, halt_req}, 32'h0);
        rd(8'h40, d); check("R10 unmapped offset", d, 32'h0);

        // R5: set wins over clear on the same edge
        wr(A_CTL, ctl(4'h5, 1'b1, 1'b0));
        xfer_valid = 1'b1; xfer_addr = 32'h0000_2000; xfer_tag = 4'h5;
        tick();
        xfer_valid = 1'b0;
        wr(A_CTL, ctl(4'h5, 1'b1, 1'b0));
        rd(A_CTL, d); check("R5 set wins", {31'h0, d[16]}, 32'h1);
        wr(A_CTL, ctl(4'h5, 1'b1, 1'b0));
        rd(A_CTL, d); check("R4 clear in debug", {31'h0, d[16]}, 32'h0);

        // R3: invalid strobe
        xfer(1'b0, 32'h0000_2000, 4'h5);
        rd(A_CTL, d); check("R3 no hit when idle", {31'h0, d[16]}, 32'h0);

        // R9: test reset clears everything
        trst = 1'b1; tick(); trst = 1'b0;
        rd(A_CTL, d); check("R9 trst ctl", d, 32'h0);
        rd(A_WA, d);  check("R9 trst waddr", d, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule